// File: doc/BRIEF.md
# Multiplexed 8-bit Host Register Port

This block lets an external host reach a small bank of on-chip registers through a few general-purpose pins. A single 8-bit bus carries both the register index and the register data. An address/data select line tells the port which of the two the current cycle carries. The host works with active-low chip-select, write and read strobes, and the port answers on an active-low ready line. The port also drives an active-low interrupt line back to the host.

Each access has two steps. First the host performs an address cycle: a write strobe with the select line high, which stores the low four bits of the bus as the current index. Then it performs a data cycle: a write or read strobe with the select line low, which acts on the register at that index. The index is kept after a data cycle, so the host can repeat data cycles on the same register without a new address cycle.

On the chip side, the port gives a one-cycle write strobe and a one-cycle read strobe, an index and write data, and it samples read data in the same cycle as the read strobe. The host pins are asynchronous to the chip clock and go through synchronizers. The bus is split into an input, an output and an output enable, which a pad drives.

The port decodes a 16-entry index space. Only some entries are implemented and reach the bank. One entry returns a fixed revision byte. The remaining entries read as zero.

Top module: `hostport_regif`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `host_rdy_no` and `host_int_no` are high, `host_data_oe_o` is low with `host_cs_n_i` high, `host_data_o` is 8'h00, and the current index is 0.
- R2: A write strobe with `host_ad_i` high stores `host_data_i[3:0]` as the current index. `host_data_i[7:4]` is ignored, and no bank strobe is issued.
- R3: A write strobe with `host_ad_i` low, to an implemented index, gives exactly one `reg_wr_o` pulse. During that pulse `reg_idx_o` holds the current index and `reg_wdata_o` holds the bus byte.
- R4: A read strobe with `host_ad_i` low, to an implemented index, gives exactly one `reg_rd_o` pulse. The `reg_rdata_i` byte sampled in that cycle then appears on `host_data_o`.
- R5: Index 15 is the revision entry. A read returns the `REVISION` parameter (default 8'h5C). A write is dropped and produces no bank strobe.
- R6: Implemented indices are the set bits of `IMPL_MASK` (default 16'hB7F3: indices 0, 1, 4 to 10, 12, 13 and 15). For indices 2, 3, 11 and 14, writes give no strobe, and reads give no strobe and return 8'h00.
- R7: `host_data_oe_o` is high only while both `host_cs_n_i` and `host_rd_n_i` are low.
- R8: `host_rdy_no` falls only after the access has been carried out. It stays low while the strobe is held, and it rises after the strobe or the chip select is released. Each strobe assertion performs exactly one access.
- R9: The current index is kept across data cycles. Repeated data reads without a new address cycle return the same register.
- R10: A read strobe with `host_ad_i` high returns the current index zero-extended to 8 bits. It issues no bank strobe.
- R11: `host_int_no` is the inverse of `irq_req_i`, registered once.
- R12: With `host_cs_n_i` high, the write and read strobes have no effect: there is no access, no index change and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_i | input | 8 | Bus value from the host pad |
| host_data_o | output | 8 | Read byte driven toward the host |
| host_data_oe_o | output | 1 | Pad output enable for the bus |
| host_ad_i | input | 1 | High: the cycle carries an index; low: it carries data |
| host_cs_n_i | input | 1 | Chip select, active low |
| host_wr_n_i | input | 1 | Write strobe, active low |
| host_rd_n_i | input | 1 | Read strobe, active low |
| host_rdy_no | output | 1 | Access complete, active low |
| host_int_no | output | 1 | Interrupt to the host, active low |
| reg_idx_o | output | 4 | Current register index |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_wr_o | output | 1 | One-cycle bank write strobe |
| reg_rd_o | output | 1 | One-cycle bank read strobe |
| reg_rdata_i | input | 8 | Bank read data, sampled with `reg_rd_o` |
| irq_req_i | input | 1 | Interrupt request from the chip side |

## Verification
The hardest case to reach from the ports is a data cycle issued long after its address cycle. It must still hit the stored index, and one long strobe must not turn into several accesses. The stimulus sweeps every one of the 16 indices. For each index it writes a byte computed from the index, then reads it back twice with no new address cycle, holding each strobe several cycles beyond ready. It also reads the index back through the select line. Strobes with chip select high are applied in between, to show that the stored index survives them.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  typedef enum logic {
    HP_IDLE = 1'b0,
    HP_HOLD = 1'b1
  } hp_state_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned        W       = 4,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hp_decode.sv
module hp_decode #(
  parameter int unsigned          IDX_W     = 4,
  parameter int unsigned          NUM_REGS  = 16,
  parameter logic [NUM_REGS-1:0]  IMPL_MASK = '1,
  parameter int unsigned          REV_IDX   = 15
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o,
  output logic             rev_o
);
  logic [NUM_REGS-1:0] hit_vec;

  // entries that reach the bank: implemented and not the revision slot
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    if (IMPL_MASK[g] && (g != REV_IDX)) begin : g_on
      assign hit_vec[g] = 1'b1;
    end else begin : g_off
      assign hit_vec[g] = 1'b0;
    end
  end

  assign hit_o = hit_vec[idx_i];
  assign rev_o = (idx_i == IDX_W'(REV_IDX));
endmodule

// File: rtl/hp_access_fsm.sv
module hp_access_fsm
  import hostport_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       IDX_W    = 4,
  parameter logic [DATA_W-1:0] REVISION = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              wr_n_s_i,
  input  logic              rd_n_s_i,
  input  logic              ad_s_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hit_i,
  input  logic              rev_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_no
);
  hp_state_e         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rdy_n_q;
  logic              wr_go, rd_go, strobe_off;

  // write wins when both strobes are low
  assign wr_go      = (st_q == HP_IDLE) && !cs_n_s_i && !wr_n_s_i;
  assign rd_go      = (st_q == HP_IDLE) && !cs_n_s_i && !rd_n_s_i && wr_n_s_i;
  assign strobe_off = cs_n_s_i || (wr_n_s_i && rd_n_s_i);

  assign reg_wr_o = wr_go && !ad_s_i && hit_i;
  assign reg_rd_o = rd_go && !ad_s_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HP_IDLE;
      idx_q   <= '0;
      rdata_q <= '0;
      rdy_n_q <= 1'b1;
    end else begin
      unique case (st_q)
        HP_IDLE: begin
          if (wr_go || rd_go) begin
            st_q    <= HP_HOLD;
            rdy_n_q <= 1'b0;
          end
          if (wr_go && ad_s_i) idx_q <= data_i[IDX_W-1:0];
          if (rd_go) begin
            if (ad_s_i)     rdata_q <= DATA_W'(idx_q);
            else if (rev_i) rdata_q <= REVISION;
            else if (hit_i) rdata_q <= reg_rdata_i;
            else            rdata_q <= '0;
          end
        end
        HP_HOLD: begin
          if (strobe_off) begin
            st_q    <= HP_IDLE;
            rdy_n_q <= 1'b1;
          end
        end
        default: st_q <= HP_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign rdata_o = rdata_q;
  assign rdy_no  = rdy_n_q;
endmodule

// File: rtl/hostport_regif.sv
module hostport_regif #(
  parameter int unsigned                 DATA_W      = 8,
  parameter int unsigned                 IDX_W       = 4,
  parameter int unsigned                 SYNC_STAGES = 2,
  parameter logic [(1<<IDX_W)-1:0]       IMPL_MASK   = 16'hB7F3,
  parameter int unsigned                 REV_IDX     = 15,
  parameter logic [DATA_W-1:0]           REVISION    = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  input  logic              host_ad_i,
  input  logic              host_cs_n_i,
  input  logic              host_wr_n_i,
  input  logic              host_rd_n_i,
  output logic              host_rdy_no,
  output logic              host_int_no,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              irq_req_i
);
  localparam int unsigned NUM_REGS = 1 << IDX_W;
  localparam int unsigned CTRL_W   = 4;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              cs_n_s, wr_n_s, rd_n_s, ad_s;
  logic [IDX_W-1:0]  idx;
  logic              hit, rev;
  logic              int_n_q;

  assign ctrl_raw = {host_ad_i, host_rd_n_i, host_wr_n_i, host_cs_n_i};

  hp_sync #(
    .W       (CTRL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0111)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_raw),
    .q_o    (ctrl_s)
  );

  assign {ad_s, rd_n_s, wr_n_s, cs_n_s} = ctrl_s;

  hp_decode #(
    .IDX_W     (IDX_W),
    .NUM_REGS  (NUM_REGS),
    .IMPL_MASK (IMPL_MASK),
    .REV_IDX   (REV_IDX)
  ) i_decode (
    .idx_i (idx),
    .hit_o (hit),
    .rev_o (rev)
  );

  hp_access_fsm #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .REVISION (REVISION)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_s_i    (cs_n_s),
    .wr_n_s_i    (wr_n_s),
    .rd_n_s_i    (rd_n_s),
    .ad_s_i      (ad_s),
    .data_i      (host_data_i),
    .hit_i       (hit),
    .rev_i       (rev),
    .reg_rdata_i (reg_rdata_i),
    .idx_o       (idx),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .rdata_o     (host_data_o),
    .rdy_no      (host_rdy_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_n_q <= 1'b1;
    else         int_n_q <= ~irq_req_i;
  end

  // pad enable follows raw pins so the bus is released at once
  assign host_data_oe_o = !host_cs_n_i && !host_rd_n_i;
  assign host_int_no    = int_n_q;
  assign reg_idx_o      = idx;
  assign reg_wdata_o    = host_data_i;
endmodule

// File: rtl/hostport_regif_chk.sv
module hostport_regif_chk #(
  parameter int unsigned           IDX_W     = 4,
  parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = 16'hB7F3,
  parameter int unsigned           REV_IDX   = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_rdy_no,
  input logic             host_int_no,
  input logic             reg_wr_o,
  input logic             reg_rd_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             irq_req_i
);
  // R3 / R8: one bank strobe per access
  a_r3_wr_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  a_r4_rd_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  // R5 / R6: strobes reach only implemented, non-revision entries
  a_r6_mapped_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |-> (IMPL_MASK[reg_idx_o] && (reg_idx_o != IDX_W'(REV_IDX))));
  // R8: ready follows the bank strobe, never precedes it
  a_r8_rdy_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |-> host_rdy_no ##1 !host_rdy_no);
  // R11: interrupt is the registered inverse of the request
  a_r11_int_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> !host_int_no);
  a_r11_int_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_i |=> host_int_no);
endmodule

bind hostport_regif hostport_regif_chk #(
  .IDX_W     (IDX_W),
  .IMPL_MASK (IMPL_MASK),
  .REV_IDX   (REV_IDX)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_rdy_no (host_rdy_no),
  .host_int_no (host_int_no),
  .reg_wr_o    (reg_wr_o),
  .reg_rd_o    (reg_rd_o),
  .reg_idx_o   (reg_idx_o),
  .irq_req_i   (irq_req_i)
);

// File: tb/test_hostport_regif.sv
module test_hostport_regif;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] MASK       = 16'hB7F3;
  localparam logic [7:0]  REV        = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] host_data_i = 8'h00;
  logic [7:0] host_data_o;
  logic       host_data_oe_o;
  logic       host_ad_i = 1'b0, host_cs_n_i = 1'b1, host_wr_n_i = 1'b1, host_rd_n_i = 1'b1;
  logic       host_rdy_no, host_int_no;
  logic [3:0] reg_idx_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic       reg_wr_o, reg_rd_o;
  logic       irq_req_i = 1'b0;

  logic [7:0] bank [16];
  int         wr_cnt = 0, rd_cnt = 0;
  int         vectors = 0, fails = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_regif i_hostport_regif (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe_o(host_data_oe_o),
    .host_ad_i(host_ad_i), .host_cs_n_i(host_cs_n_i), .host_wr_n_i(host_wr_n_i),
    .host_rd_n_i(host_rd_n_i), .host_rdy_no(host_rdy_no), .host_int_no(host_int_no),
    .reg_idx_o(reg_idx_o), .reg_wdata_o(reg_wdata_o), .reg_wr_o(reg_wr_o),
    .reg_rd_o(reg_rd_o), .reg_rdata_i(reg_rdata_i), .irq_req_i(irq_req_i)
  );

  // bench-side register bank
  assign reg_rdata_i = bank[reg_idx_o];
  always @(posedge clk) begin
    if (reg_wr_o) begin bank[reg_idx_o] <= reg_wdata_o; wr_cnt <= wr_cnt + 1; end
    if (reg_rd_o) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // one strobe assertion; hold extra cycles after ready to catch repeats
  task automatic host_access(input logic ad, input logic rd, input logic [7:0] wdat,
                             output logic [7:0] rdat, output logic oe_seen);
    int k;
    logic got;
    @(negedge clk);
    host_ad_i = ad; host_data_i = wdat; host_cs_n_i = 1'b0;
    @(negedge clk);
    if (rd) host_rd_n_i = 1'b0; else host_wr_n_i = 1'b0;
    got = 1'b0; k = 0;
    while (!got && k < 20) begin
      @(negedge clk); k++;
      if (!host_rdy_no) got = 1'b1;
    end
    check("R8 ready asserted", 32'(got), 32'd1);
    repeat (4) @(negedge clk);
    check("R8 ready held", 32'(host_rdy_no), 32'd0);
    rdat = host_data_o; oe_seen = host_data_oe_o;
    host_wr_n_i = 1'b1; host_rd_n_i = 1'b1;
    @(negedge clk);
    host_cs_n_i = 1'b1;
    got = 1'b0; k = 0;
    while (!got && k < 20) begin
      @(negedge clk); k++;
      if (host_rdy_no) got = 1'b1;
    end
    check("R8 ready released", 32'(got), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd_v, wdat, exp_rd;
    logic       oe;
    logic       mapped;
    int         w0, r0;
    for (int i = 0; i < 16; i++) bank[i] = 8'hEE;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 rdy in reset", 32'(host_rdy_no), 32'd1);
    check("R1 oe in reset", 32'(host_data_oe_o), 32'd0);
    check("R1 int in reset", 32'(host_int_no), 32'd1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdy after reset", 32'(host_rdy_no), 32'd1);
    check("R1 data after reset", 32'(host_data_o), 32'h00);
    check("R1 index after reset", 32'(reg_idx_o), 32'd0);
    check("R1 int after reset", 32'(host_int_no), 32'd1);

    // sweep of all indices
    for (int i = 0; i < 16; i++) begin
      mapped = MASK[i] && (i != 15);
      w0 = wr_cnt; r0 = rd_cnt;
      host_access(1'b1, 1'b0, {~4'(i), 4'(i)}, rd_v, oe);
      check("R2 index stored", 32'(reg_idx_o), 32'(i));
      check("R2 no strobe on address cycle", 32'(wr_cnt - w0 + rd_cnt - r0), 32'd0);

      wdat = 8'((i * 29 + 7) & 8'hFF);
      w0 = wr_cnt;
      host_access(1'b0, 1'b0, wdat, rd_v, oe);
      check(i == 15 ? "R5 write dropped" : (mapped ? "R3 write pulse" : "R6 write dropped"),
            32'(wr_cnt - w0), mapped ? 32'd1 : 32'd0);
      if (mapped) check("R3 bank byte", 32'(bank[i]), 32'(wdat));

      exp_rd = (i == 15) ? REV : (mapped ? wdat : 8'h00);
      for (int rep = 0; rep < 2; rep++) begin
        r0 = rd_cnt;
        host_access(1'b0, 1'b1, 8'h00, rd_v, oe);
        check(i == 15 ? "R5 revision read" : (mapped ? "R4 read data" : "R6 unmapped read"),
              32'(rd_v), 32'(exp_rd));
        check(mapped ? "R4 read pulse" : "R6 no read pulse", 32'(rd_cnt - r0),
              mapped ? 32'd1 : 32'd0);
        check("R7 oe during read", 32'(oe), 32'd1);
        if (rep == 1) check("R9 index kept", 32'(reg_idx_o), 32'(i));
      end

      r0 = rd_cnt;
      host_access(1'b1, 1'b1, 8'h00, rd_v, oe);
      check("R10 index readback", 32'(rd_v), 32'(i));
      check("R10 no bank strobe", 32'(rd_cnt - r0), 32'd0);
    end

    // R12 strobes without chip select; R7 oe off
    w0 = wr_cnt;
    @(negedge clk);
    host_ad_i = 1'b1; host_data_i = 8'h0B; host_wr_n_i = 1'b0;
    repeat (8) @(negedge clk);
    check("R12 no ready without cs", 32'(host_rdy_no), 32'd1);
    host_wr_n_i = 1'b1; host_rd_n_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 oe off with cs high", 32'(host_data_oe_o), 32'd0);
    host_rd_n_i = 1'b1; host_cs_n_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 oe off with rd high", 32'(host_data_oe_o), 32'd0);
    host_cs_n_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 index unchanged", 32'(reg_idx_o), 32'd15);
    check("R12 no strobe", 32'(wr_cnt - w0), 32'd0);

    // R11 interrupt
    irq_req_i = 1'b1;
    @(negedge clk);
    check("R11 int asserted", 32'(host_int_no), 32'd0);
    irq_req_i = 1'b0;
    @(negedge clk);
    check("R11 int released", 32'(host_int_no), 32'd1);

    finish_run();
  end
endmodule